// File: doc/BRIEF.md
# Aligned Bitmap Buffer Allocator

This block manages a 16 KiB shared buffer memory as 64 blocks of 256 bytes. Occupancy is kept in a bitmap of two 32-bit words: bit `b` of word `w` stands for block `32*w + b`. A client sends an allocation request with a byte size and receives the byte offset of a free region. It can also send a release request with an offset and a size, and the matching blocks are marked free again. The memory itself is not part of the block. Only its bookkeeping is.

An allocation rounds the size up to whole blocks. It then picks a search stride: the smallest power of two, from 1 to 32 blocks, that holds that many blocks. Candidate slots lie only at multiples of the stride and never straddle a map word. The search tests one candidate per clock. It works through word 0 first and then word 1, and it takes the first slot whose needed bits are all clear. Failure is reported as an offset equal to the memory size, 16384.

Requests use a single-cycle `req_valid` strobe. The block raises `busy` while it works and pulses `done` for one cycle with the result on `resp_offset`.

Top module: `bmalloc_top`

## Requirements
- R1: A synchronous active-high reset marks every block free and drives `busy`, `done` and `resp_offset` to zero.
- R2: An allocation marks exactly ceil(size/256) blocks. Its search stride is the smallest power of two, from 1 to 32, that is at least that count. The marked run can therefore be shorter than the stride.
- R3: An allocation of size 0, or of more than 8192 bytes (over 32 blocks), returns 16384 with `done` one cycle after acceptance.
- R4: Candidates start at bit 0 of word 0 and advance by the stride. Word 1 is searched only after all of word 0. The first candidate whose needed bits are all free is chosen, so every returned offset is a multiple of 256 times the stride.
- R5: `req_op` = 0 selects allocation. On success the needed bits are set and `resp_offset` = (32*word + bit) * 256.
- R6: When no candidate fits, the result is 16384 and the bitmap is unchanged.
- R7: `req_op` = 1 selects release. With k = offset/256, it clears ceil(size/256) bits (saturated at 32) starting at bit k mod 32 of word k/32. Bits that would pass bit 31 are dropped, and size 0 releases nothing. `resp_offset` echoes the offset.
- R8: One candidate is tested per clock. When candidate n (counted from 0) is the one chosen, or the last one tried, `done` is seen n+1 cycles after the accepting edge. A release completes in 1 cycle.
- R9: A request is accepted only while `busy` is low. `busy` is high from acceptance until `done`. `done` lasts exactly one cycle, and requests presented while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_size | input | 16 | Request size in bytes |
| req_offset | input | 15 | Byte offset of the region to release |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion pulse |
| resp_offset | output | 15 | Allocated offset, 16384 on failure, echoed offset on release |

## Verification
Some behaviours are checked on every cycle by assertions:
- an allocation never marks a bit that is already set;
- set and clear operations land in the bitmap;
- failures carry the 16384 code;
- returned offsets respect the stride alignment;
- `done` is a single-cycle pulse that never overlaps `busy`.

Other behaviours only the bench scenarios can show: the exact first-fit choice, the per-candidate latency, the partial-stride marking, the dropping of release bits past a word end, and a request ignored while busy. Each of these appears in the bench as a later allocation whose offset or latency would differ if the bitmap had been altered.

// File: rtl/bmalloc_pkg.sv
package bmalloc_pkg;
  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FREE   = 2'd2
  } state_e;
endpackage

// File: rtl/bmalloc_size_decode.sv
// Turns a byte size into a block count mask and a power-of-two search stride.
module bmalloc_size_decode #(
  parameter  int SIZE_W    = 16,
  parameter  int BLK_SH    = 8,
  parameter  int WORD_BITS = 32,
  localparam int CNT_W     = SIZE_W + 1 - BLK_SH,
  localparam int MAXLOG    = $clog2(WORD_BITS),
  localparam int LOG_W     = $clog2(MAXLOG + 1)
) (
  input  logic [SIZE_W-1:0]    size,
  output logic                 valid,
  output logic [LOG_W-1:0]     span_log,
  output logic [WORD_BITS-1:0] need_mask
);
  localparam logic [SIZE_W:0] ROUND = (SIZE_W + 1)'((1 << BLK_SH) - 1);

  logic [CNT_W-1:0] blocks;

  // Ceiling division by the block size.
  assign blocks = CNT_W'(({1'b0, size} + ROUND) >> BLK_SH);
  assign valid  = (size != '0) && (blocks <= CNT_W'(WORD_BITS));

  // Smallest power of two covering the count: descending scan, last hit wins.
  always_comb begin
    span_log = LOG_W'(MAXLOG);
    for (int i = MAXLOG; i >= 0; i--) begin
      if ((CNT_W'(1) << i) >= blocks) span_log = LOG_W'(i);
    end
  end

  // Low-order run of ones, saturating at a full word.
  always_comb begin
    for (int b = 0; b < WORD_BITS; b++) need_mask[b] = (CNT_W'(b) < blocks);
  end
endmodule

// File: rtl/bmalloc_slot_probe.sv
// Places a run mask at a bit position and tests it against one map word.
module bmalloc_slot_probe #(
  parameter  int MAP_WORDS = 2,
  parameter  int WORD_BITS = 32,
  localparam int WIDX_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1,
  localparam int POS_W     = $clog2(WORD_BITS)
) (
  input  logic [MAP_WORDS-1:0][WORD_BITS-1:0] map,
  input  logic [WIDX_W-1:0]                   widx,
  input  logic [POS_W-1:0]                    pos,
  input  logic [WORD_BITS-1:0]                need_mask,
  output logic [WORD_BITS-1:0]                place_mask,
  output logic                                fits
);
  logic [WORD_BITS-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < MAP_WORDS; w++) begin
      if (WIDX_W'(w) == widx) sel_word = map[w];
    end
  end

  assign place_mask = need_mask << pos;
  assign fits       = ((sel_word & place_mask) == '0);
endmodule

// File: rtl/bmalloc_bitmap.sv
// Occupancy registers: one word per map entry, bit set means block in use.
module bmalloc_bitmap #(
  parameter  int MAP_WORDS = 2,
  parameter  int WORD_BITS = 32,
  localparam int WIDX_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                set_en,
  input  logic                                clr_en,
  input  logic [WIDX_W-1:0]                   widx,
  input  logic [WORD_BITS-1:0]                mask,
  output logic [MAP_WORDS-1:0][WORD_BITS-1:0] map_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else begin
      for (int w = 0; w < MAP_WORDS; w++) begin
        if (WIDX_W'(w) == widx) begin
          if (set_en)      map_q[w] <= map_q[w] | mask;
          else if (clr_en) map_q[w] <= map_q[w] & ~mask;
        end
      end
    end
  end

  logic [WORD_BITS-1:0] cur_word;
  always_comb begin
    cur_word = '0;
    for (int w = 0; w < MAP_WORDS; w++) begin
      if (WIDX_W'(w) == widx) cur_word = map_q[w];
    end
  end

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (map_q == '0));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    set_en |-> ((cur_word & mask) == '0));

  p_set_lands_r5: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((map_q[$past(widx)] & $past(mask)) == $past(mask)));

  p_clear_lands_r7: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((map_q[$past(widx)] & $past(mask)) == '0));

  p_single_op_r9: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
endmodule

// File: rtl/bmalloc_top.sv
// Bitmap allocator: aligned first-fit search, one candidate per clock.
module bmalloc_top #(
  parameter  int MEM_BYTES = 16384,
  parameter  int MAP_WORDS = 2,
  parameter  int WORD_BITS = 32,
  parameter  int SIZE_W    = 16,
  localparam int BLOCKS    = MAP_WORDS * WORD_BITS,
  localparam int BLK_BYTES = MEM_BYTES / BLOCKS,
  localparam int BLK_SH    = $clog2(BLK_BYTES),
  localparam int OFF_W     = $clog2(MEM_BYTES) + 1,
  localparam int WIDX_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1,
  localparam int POS_W     = $clog2(WORD_BITS),
  localparam int LOG_W     = $clog2(POS_W + 1),
  localparam int FBLK_W    = OFF_W - BLK_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  resp_offset
);
  import bmalloc_pkg::*;

  localparam logic [OFF_W-1:0] OOM = OFF_W'(MEM_BYTES);

  state_e              state_q;
  op_e                 op_q;
  logic [SIZE_W-1:0]   size_q;
  logic [OFF_W-1:0]    off_q;
  logic [WIDX_W-1:0]   widx_q;
  logic [POS_W-1:0]    pos_q;
  logic                busy_q, done_q;
  logic [OFF_W-1:0]    resp_q;

  // Size decode (shared by both operations).
  logic                 dec_valid;
  logic [LOG_W-1:0]     span_log;
  logic [WORD_BITS-1:0] need_mask;

  bmalloc_size_decode #(
    .SIZE_W(SIZE_W), .BLK_SH(BLK_SH), .WORD_BITS(WORD_BITS)
  ) u_dec (
    .size(size_q), .valid(dec_valid), .span_log(span_log), .need_mask(need_mask)
  );

  // Release addressing.
  logic [FBLK_W-1:0] free_blk, free_word;
  logic [POS_W-1:0]  free_bit;
  logic              free_in_range;

  assign free_blk      = off_q[OFF_W-1:BLK_SH];
  assign free_word     = free_blk >> POS_W;
  assign free_bit      = free_blk[POS_W-1:0];
  assign free_in_range = (free_word < FBLK_W'(MAP_WORDS));

  // Probe: search candidate, or the release location.
  logic [MAP_WORDS-1:0][WORD_BITS-1:0] map_q;
  logic [WIDX_W-1:0]    probe_widx;
  logic [POS_W-1:0]     probe_pos;
  logic [WORD_BITS-1:0] place_mask;
  logic                 fits;

  assign probe_widx = (state_q == ST_FREE) ? free_word[WIDX_W-1:0] : widx_q;
  assign probe_pos  = (state_q == ST_FREE) ? free_bit : pos_q;

  bmalloc_slot_probe #(
    .MAP_WORDS(MAP_WORDS), .WORD_BITS(WORD_BITS)
  ) u_probe (
    .map(map_q), .widx(probe_widx), .pos(probe_pos), .need_mask(need_mask),
    .place_mask(place_mask), .fits(fits)
  );

  logic set_en, clr_en;
  assign set_en = (state_q == ST_SEARCH) && dec_valid && fits;
  assign clr_en = (state_q == ST_FREE) && free_in_range;

  bmalloc_bitmap #(
    .MAP_WORDS(MAP_WORDS), .WORD_BITS(WORD_BITS)
  ) u_map (
    .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en),
    .widx(probe_widx), .mask(place_mask), .map_q(map_q)
  );

  // Candidate stepping.
  logic [POS_W:0]            next_pos;
  logic                      wrap, last_cand;
  logic [WIDX_W+POS_W-1:0]   blk_found;
  logic [OFF_W-1:0]          found_off;

  assign next_pos  = {1'b0, pos_q} + ((POS_W + 1)'(1) << span_log);
  assign wrap      = next_pos[POS_W];
  assign last_cand = wrap && (widx_q == WIDX_W'(MAP_WORDS - 1));
  assign blk_found = {widx_q, pos_q};
  assign found_off = OFF_W'(blk_found) << BLK_SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ALLOC;
      size_q  <= '0;
      off_q   <= '0;
      widx_q  <= '0;
      pos_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      resp_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= op_e'(req_op);
            size_q  <= req_size;
            off_q   <= req_offset;
            widx_q  <= '0;
            pos_q   <= '0;
            busy_q  <= 1'b1;
            state_q <= req_op ? ST_FREE : ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (!dec_valid || fits || last_cand) begin
            resp_q  <= (dec_valid && fits) ? found_off : OOM;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (wrap) begin
            widx_q <= WIDX_W'(widx_q + 1'b1);
            pos_q  <= '0;
          end else begin
            pos_q <= next_pos[POS_W-1:0];
          end
        end
        ST_FREE: begin
          resp_q  <= off_q;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign resp_offset = resp_q;

  // Alignment helper for checks.
  logic [POS_W-1:0] span_low;
  logic [OFF_W-1:0] resp_blk;
  assign span_low = POS_W'((32'(1) << span_log) - 1);
  assign resp_blk = resp_q >> BLK_SH;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  p_busy_from_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(req_valid));

  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(size_q) && $stable(off_q)));

  p_fail_code_r3: assert property (@(posedge clk) disable iff (rst)
    (done_q && op_q == OP_ALLOC && !dec_valid) |-> (resp_q == OOM));

  p_span_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && op_q == OP_ALLOC && resp_q != OOM) |->
      ((resp_q < OOM) && (POS_W'(resp_blk) & span_low) == '0));
endmodule

// File: tb/bmalloc_top_tb.sv
`timescale 1ns/1ps
module bmalloc_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [15:0] req_size = '0;
  logic [14:0] req_offset = '0;
  logic        busy, done;
  logic [14:0] resp_offset;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  bmalloc_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_offset(req_offset),
    .busy(busy), .done(done), .resp_offset(resp_offset)
  );

  typedef struct packed {
    logic        op;
    logic [15:0] size;
    logic [14:0] off;
    logic [14:0] exp;
    logic [7:0]  lat;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd256,   15'd0,    15'd0,     8'd1},
    '{1'b0, 16'd300,   15'd0,    15'd512,   8'd2},
    '{1'b0, 16'd1,     15'd0,    15'd256,   8'd2},
    '{1'b0, 16'd1000,  15'd0,    15'd1024,  8'd2},
    '{1'b0, 16'd1500,  15'd0,    15'd2048,  8'd2},
    '{1'b0, 16'd256,   15'd0,    15'd3584,  8'd15},
    '{1'b0, 16'd8192,  15'd0,    15'd8192,  8'd2},
    '{1'b0, 16'd8193,  15'd0,    15'd16384, 8'd1},
    '{1'b0, 16'd0,     15'd0,    15'd16384, 8'd1},
    '{1'b0, 16'd4096,  15'd0,    15'd4096,  8'd2},
    '{1'b0, 16'd512,   15'd0,    15'd16384, 8'd32},
    '{1'b0, 16'd1,     15'd0,    15'd3840,  8'd16},
    '{1'b1, 16'd8192,  15'd8192, 15'd8192,  8'd1},
    '{1'b0, 16'd512,   15'd0,    15'd8192,  8'd17},
    '{1'b1, 16'd300,   15'd512,  15'd512,   8'd1},
    '{1'b0, 16'd600,   15'd0,    15'd9216,  8'd10},
    '{1'b0, 16'd256,   15'd0,    15'd512,   8'd3},
    '{1'b1, 16'd0,     15'd256,  15'd256,   8'd1},
    '{1'b0, 16'd256,   15'd0,    15'd768,   8'd4},
    '{1'b1, 16'd512,   15'd7936, 15'd7936,  8'd1},
    '{1'b0, 16'd256,   15'd0,    15'd7936,  8'd32},
    '{1'b0, 16'd256,   15'd0,    15'd8704,  8'd35},
    '{1'b0, 16'd16384, 15'd0,    15'd16384, 8'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic op, input logic [15:0] size,
                         input logic [14:0] off, output int resp,
                         output int lat, output logic busy_seen);
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    req_size   = size;
    req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = busy;
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    resp = int'(resp_offset);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog act=timeout exp=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int resp, lat;
    logic bs;

    repeat (3) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 resp after reset", int'(resp_offset), 0);
    rst = 1'b0;

    // Table walk: allocate (op 0) and release (op 1) sequence from an empty map.
    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i].op, VEC[i].size, VEC[i].off, resp, lat, bs);
      if (VEC[i].op)
        chk($sformatf("R7 release vec%0d", i), resp, int'(VEC[i].exp));
      else if (VEC[i].exp == 15'd16384)
        chk($sformatf("R3 R6 fail code vec%0d", i), resp, int'(VEC[i].exp));
      else
        chk($sformatf("R2 R4 R5 offset vec%0d", i), resp, int'(VEC[i].exp));
      chk($sformatf("R8 latency vec%0d", i), lat, int'(VEC[i].lat));
      chk($sformatf("R9 busy after accept vec%0d", i), int'(bs), 1);
    end

    // Reset mid-life clears the whole map: a 32-block request lands at 0.
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    run_req(1'b0, 16'd8192, 15'd0, resp, lat, bs);
    chk("R1 map empty after reset", resp, 0);
    chk("R8 first-candidate latency", lat, 1);
    run_req(1'b0, 16'd8192, 15'd0, resp, lat, bs);
    chk("R4 second word used", resp, 8192);

    // Long failing search with a release presented while busy.
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_size = 16'd256; req_offset = '0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    chk("R9 busy during search", int'(busy), 1);
    req_valid = 1'b1; req_op = 1'b1; req_size = 16'd8192; req_offset = 15'd0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    chk("R6 full map fails", int'(resp_offset), 16384);
    chk("R8 all 64 candidates", lat, 64);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
    chk("R9 no accept from ignored request", int'(busy), 0);
    run_req(1'b0, 16'd256, 15'd0, resp, lat, bs);
    chk("R9 release while busy ignored", resp, 16384);

    // Release one block in word 0, then it is found again.
    run_req(1'b1, 16'd256, 15'd0, resp, lat, bs);
    chk("R8 release latency", lat, 1);
    run_req(1'b0, 16'd256, 15'd0, resp, lat, bs);
    chk("R7 released block reused", resp, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule